// File: doc/BRIEF.md
# Windowed Scan Self-Test Sequencer

This block sequences a pseudo-random, scan-based self-test. A run is a fixed number of tests, grouped into equal-sized windows. For each test the sequencer first fills the scan chain, stepping the scan-input pattern generator and the shift clocks together. It then steps the primary-input pattern generator once and pulses the functional clocks to capture the responses. Next it steps the output compactor once. The captured chain contents are shifted into a serial compactor while the next test's pattern is shifted in. After the last test there is no next load, so the sequencer runs one extra unload-only shift phase.

In full-run mode the signatures are compared once, at the end of the run. In diagnostic mode the sequencer stops after every window: it flushes the chain, requests a compare for that window and halts at the first window whose signature is wrong. It then reports the index of that window. The comparison itself is done outside the block and returned on `sig_match`. The signature registers and the expected values also live outside the block.

Top module: `scan_bist_seq`

## Requirements
- R1: After reset, `done`, `pass`, `fail` and all strobe outputs (`scan_gen_step`, `shift_clk`, `pi_gen_step`, `func_clk`, `po_comp_step`, `serial_comp_step`, `cmp_req`) are 0.
- R2: Each test begins with CHAIN_LEN consecutive cycles in which `scan_gen_step` and `shift_clk` are both 1. `scan_gen_step` is never 1 without `shift_clk`.
- R3: After the load, there is one cycle of `pi_gen_step`, then CAP_CYCLES cycles of `func_clk`, then one cycle of `po_comp_step`. At most one of `shift_clk`, `pi_gen_step`, `func_clk`, `po_comp_step` and `cmp_req` is 1 in any cycle.
- R4: `serial_comp_step` accompanies every load shift cycle except those of the first test after start, or after a diagnostic window compare. It is never 1 without `shift_clk`.
- R5: After the last test of a run, and in diagnostic mode after the last test of every window, there are CHAIN_LEN cycles with `shift_clk` and `serial_comp_step` at 1 and `scan_gen_step` at 0. These cycles are followed by one `cmp_req` cycle.
- R6: In full-run mode (`diag_mode`=0 at start), exactly one compare is requested, with `cmp_win` = NUM_WIN-1. The run ends with `pass`=1 if `sig_match` was 1, otherwise with `fail`=1 and `fail_win`=NUM_WIN-1.
- R7: In diagnostic mode (`diag_mode`=1 at start), window w (counting from 0) is followed by a compare with `cmp_win`=w. When `sig_match`=0 at such a compare, the run stops in the next cycle with `done`=1, `fail`=1 and `fail_win`=w.
- R8: In diagnostic mode with every compare matching, NUM_WIN compares occur and the run ends with `pass`=1.
- R9: `done`, `pass`, `fail` and `fail_win` hold their values until the next accepted start. `start` is ignored while a run is in progress.
- R10: A run lasts a fixed number of cycles with `done`=0. In diagnostic mode this is N·(TESTS_PER_WIN·(CHAIN_LEN+CAP_CYCLES+2)+CHAIN_LEN+1), where N is the number of windows compared. In full-run mode it is NUM_WIN·TESTS_PER_WIN·(CHAIN_LEN+CAP_CYCLES+2)+CHAIN_LEN+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| diag_mode | input | 1 | Sampled at start: 1 = stop at every window, 0 = full run |
| sig_match | input | 1 | External compare result, valid while `cmp_req` is 1 |
| scan_gen_step | output | 1 | Steps the scan-input pattern generator |
| shift_clk | output | 1 | Scan chain shift clock enable |
| pi_gen_step | output | 1 | Steps the primary-input pattern generator |
| func_clk | output | 1 | Functional capture clock enable |
| po_comp_step | output | 1 | Steps the primary-output compactor |
| serial_comp_step | output | 1 | Steps the serial compactor on the scan output |
| cmp_req | output | 1 | Requests a signature compare |
| cmp_win | output | WIN_W | Index of the window being compared |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with all compares matching |
| fail | output | 1 | Run finished on a mismatch |
| fail_win | output | WIN_W | Window index of the mismatch |

## Verification
All strobes are decoded from the registered state. After start is sampled on an edge, the first load cycle is the very next cycle. Each phase then follows the previous one with no gap. `done`, `pass` and `fail` appear in the cycle after the `cmp_req` cycle that settles the run. The bench drives `start` once, clears it after the edge, and samples every output at the falling edge. It counts busy cycles and strobe pulses up to the first cycle with `done` high, and compares the totals with the closed-form cycle and pulse counts. It also checks the phase ordering cycle by cycle against the previous sample, and checks that the results stay stable for several cycles afterwards.

// File: rtl/scan_bist_seq_pkg.sv
package scan_bist_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_PIGEN,
        S_CAPT,
        S_POSTB,
        S_FLUSH,
        S_CHECK,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/bseq_wrap_cnt.sv
module bseq_wrap_cnt #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = (MAX > 1) ? $clog2(MAX) : 1;
    localparam logic [W-1:0] TOP = W'(MAX - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == TOP);

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec
    import scan_bist_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       first_load,
    output logic       scan_gen_step,
    output logic       shift_clk,
    output logic       pi_gen_step,
    output logic       func_clk,
    output logic       po_comp_step,
    output logic       serial_comp_step,
    output logic       cmp_req,
    output logic       done
);
    always_comb begin
        scan_gen_step    = (state == S_LOAD);
        shift_clk        = (state == S_LOAD) || (state == S_FLUSH);
        serial_comp_step = ((state == S_LOAD) && !first_load) || (state == S_FLUSH);
        pi_gen_step      = (state == S_PIGEN);
        func_clk         = (state == S_CAPT);
        po_comp_step     = (state == S_POSTB);
        cmp_req          = (state == S_CHECK);
        done             = (state == S_DONE);
    end
endmodule

// File: rtl/scan_bist_seq.sv
module scan_bist_seq
    import scan_bist_seq_pkg::*;
#(
    parameter int CHAIN_LEN     = 32,
    parameter int CAP_CYCLES    = 2,
    parameter int TESTS_PER_WIN = 16,
    parameter int NUM_WIN       = 8,
    localparam int WIN_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             diag_mode,
    input  logic             sig_match,
    output logic             scan_gen_step,
    output logic             shift_clk,
    output logic             pi_gen_step,
    output logic             func_clk,
    output logic             po_comp_step,
    output logic             serial_comp_step,
    output logic             cmp_req,
    output logic [WIN_W-1:0] cmp_win,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic [WIN_W-1:0] fail_win
);
    localparam logic [WIN_W-1:0] WIN_TOP = WIN_W'(NUM_WIN - 1);

    typedef struct packed {
        seq_state_e       state;
        logic             first;
        logic             diag;
        logic             pass;
        logic             fail;
        logic [WIN_W-1:0] win;
        logic [WIN_W-1:0] fail_win;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic cnt_clr, bit_inc, cap_inc, test_inc;
    logic bit_last, cap_last, test_last, win_last;

    assign win_last = (r_q.win == WIN_TOP);

    bseq_wrap_cnt #(.MAX(CHAIN_LEN)) u_bit_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(bit_inc), .last(bit_last));
    bseq_wrap_cnt #(.MAX(CAP_CYCLES)) u_cap_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cap_inc), .last(cap_last));
    bseq_wrap_cnt #(.MAX(TESTS_PER_WIN)) u_test_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(test_inc), .last(test_last));

    always_comb begin
        r_d      = r_q;
        cnt_clr  = 1'b0;
        bit_inc  = 1'b0;
        cap_inc  = 1'b0;
        test_inc = 1'b0;
        unique case (r_q.state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    r_d.state = S_LOAD;
                    r_d.first = 1'b1;
                    r_d.diag  = diag_mode;
                    r_d.pass  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.win   = '0;
                    cnt_clr   = 1'b1;
                end
            end
            S_LOAD: begin
                bit_inc = 1'b1;
                if (bit_last) r_d.state = S_PIGEN;
            end
            S_PIGEN: r_d.state = S_CAPT;
            S_CAPT: begin
                cap_inc = 1'b1;
                if (cap_last) r_d.state = S_POSTB;
            end
            S_POSTB: begin
                test_inc  = 1'b1;
                r_d.first = 1'b0;
                if (!test_last)
                    r_d.state = S_LOAD;
                else if (r_q.diag || win_last)
                    r_d.state = S_FLUSH;
                else begin
                    r_d.state = S_LOAD;
                    r_d.win   = r_q.win + 1'b1;
                end
            end
            S_FLUSH: begin
                bit_inc = 1'b1;
                if (bit_last) r_d.state = S_CHECK;
            end
            S_CHECK: begin
                if (!sig_match) begin
                    r_d.state    = S_DONE;
                    r_d.fail     = 1'b1;
                    r_d.fail_win = r_q.win;
                end else if (win_last) begin
                    r_d.state = S_DONE;
                    r_d.pass  = 1'b1;
                end else begin
                    r_d.state = S_LOAD;
                    r_d.first = 1'b1;
                    r_d.win   = r_q.win + 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, first: 1'b1, diag: 1'b0, pass: 1'b0,
                     fail: 1'b0, win: '0, fail_win: '0};
        end else begin
            r_q <= r_d;
        end
    end

    bseq_strobe_dec u_dec (
        .state           (r_q.state),
        .first_load      (r_q.first),
        .scan_gen_step   (scan_gen_step),
        .shift_clk       (shift_clk),
        .pi_gen_step     (pi_gen_step),
        .func_clk        (func_clk),
        .po_comp_step    (po_comp_step),
        .serial_comp_step(serial_comp_step),
        .cmp_req         (cmp_req),
        .done            (done)
    );

    assign cmp_win  = r_q.win;
    assign pass     = r_q.pass;
    assign fail     = r_q.fail;
    assign fail_win = r_q.fail_win;

    a_r2_scan_needs_shift: assert property (@(posedge clk) disable iff (!rst_n)
        scan_gen_step |-> shift_clk);
    a_r4_unload_needs_shift: assert property (@(posedge clk) disable iff (!rst_n)
        serial_comp_step |-> shift_clk);
    a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_clk, pi_gen_step, func_clk, po_comp_step, cmp_req}));
    a_r3_pi_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        pi_gen_step |=> func_clk);
    a_r7_stop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !sig_match) |=> (done && fail && fail_win == $past(cmp_win)));
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(fail_win)));
    a_r9_pass_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
endmodule

// File: tb/scan_bist_seq_test.sv
`timescale 1ns/1ps
module scan_bist_seq_test;
    localparam int C   = 5;
    localparam int M   = 2;
    localparam int TPW = 3;
    localparam int NW  = 4;
    localparam int WW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic diag_mode = 1'b0;
    logic sig_match;
    logic scan_gen_step, shift_clk, pi_gen_step, func_clk, po_comp_step;
    logic serial_comp_step, cmp_req, done, pass, fail;
    logic [WW-1:0] cmp_win, fail_win;

    int bad_win = NW;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    assign sig_match = (int'(cmp_win) != bad_win);

    scan_bist_seq #(.CHAIN_LEN(C), .CAP_CYCLES(M), .TESTS_PER_WIN(TPW), .NUM_WIN(NW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .diag_mode(diag_mode), .sig_match(sig_match),
        .scan_gen_step(scan_gen_step), .shift_clk(shift_clk), .pi_gen_step(pi_gen_step),
        .func_clk(func_clk), .po_comp_step(po_comp_step), .serial_comp_step(serial_comp_step),
        .cmp_req(cmp_req), .cmp_win(cmp_win), .done(done), .pass(pass), .fail(fail),
        .fail_win(fail_win));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // monitor
    bit mon = 0, fin = 0;
    int busy, c_scan, c_shift, c_sisr, c_pi, c_fc, c_po, c_cmp, early_sisr, order_err;
    int cmp_win_last;
    bit p_scan, p_pi, p_fc;

    always @(negedge clk) begin
        if (mon && !fin) begin
            if (done) fin = 1;
            else begin
                busy++;
                c_scan  += int'(scan_gen_step);
                c_shift += int'(shift_clk);
                c_sisr  += int'(serial_comp_step);
                c_pi    += int'(pi_gen_step);
                c_fc    += int'(func_clk);
                c_po    += int'(po_comp_step);
                if (cmp_req) begin c_cmp++; cmp_win_last = int'(cmp_win); end
                if (busy <= C && (serial_comp_step || !scan_gen_step)) early_sisr++;
                if (pi_gen_step && !p_scan) order_err++;
                if (func_clk && !(p_pi || p_fc)) order_err++;
                if (po_comp_step && !p_fc) order_err++;
                if ((serial_comp_step || scan_gen_step) && !shift_clk) order_err++;
                if (int'(shift_clk) + int'(pi_gen_step) + int'(func_clk)
                    + int'(po_comp_step) + int'(cmp_req) > 1) order_err++;
                p_scan = scan_gen_step; p_pi = pi_gen_step; p_fc = func_clk;
            end
        end
    end

    function automatic int n_windows(input bit d, input int b);
        if (!d) return NW;
        return (b < NW) ? b + 1 : NW;
    endfunction
    function automatic int exp_busy(input bit d, input int b);
        if (d) return n_windows(d, b) * (TPW * (C + M + 2) + C + 1);
        return NW * TPW * (C + M + 2) + C + 1;
    endfunction
    function automatic bit exp_fail(input bit d, input int b);
        return d ? (b < NW) : (b == NW - 1);
    endfunction

    task automatic run(input bit d, input int b, input bit poke);
        int tests, flushes, cmps;
        bit ef;
        busy = 0; c_scan = 0; c_shift = 0; c_sisr = 0; c_pi = 0; c_fc = 0; c_po = 0;
        c_cmp = 0; early_sisr = 0; order_err = 0; cmp_win_last = -1;
        p_scan = 0; p_pi = 0; p_fc = 0; fin = 0;
        @(negedge clk);
        bad_win = b; diag_mode = d; start = 1'b1;
        @(posedge clk); #1 start = 1'b0; mon = 1;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; diag_mode = ~d;
            @(posedge clk); #1 start = 1'b0;
        end
        while (!fin) @(negedge clk);
        mon = 0;
        tests   = n_windows(d, b) * TPW;
        flushes = d ? n_windows(d, b) : 1;
        cmps    = d ? n_windows(d, b) : 1;
        ef      = exp_fail(d, b);
        check(busy == exp_busy(d, b), "R10 busy cycles", busy, exp_busy(d, b));
        check(c_scan == tests * C, "R2 load shifts", c_scan, tests * C);
        check(c_shift == tests * C + flushes * C, "R5 total shifts", c_shift, tests * C + flushes * C);
        check(c_sisr == tests * C, "R4 unload steps", c_sisr, tests * C);
        check(early_sisr == 0, "R4 no unload in first load", early_sisr, 0);
        check(c_pi == tests && c_po == tests, "R3 pi/po steps", c_pi + c_po, 2 * tests);
        check(c_fc == tests * M, "R3 capture clocks", c_fc, tests * M);
        check(order_err == 0, "R3 phase order", order_err, 0);
        check(c_cmp == cmps, d ? "R7 compare count" : "R6 compare count", c_cmp, cmps);
        check(cmp_win_last == (d ? n_windows(d, b) - 1 : NW - 1),
              d ? "R7 last cmp_win" : "R6 cmp_win", cmp_win_last,
              d ? n_windows(d, b) - 1 : NW - 1);
        check(fail == ef && pass == !ef, d ? "R8 verdict" : "R6 verdict", int'(fail), int'(ef));
        if (ef) check(int'(fail_win) == (d ? b : NW - 1), "R7 fail_win", int'(fail_win), d ? b : NW - 1);
        repeat (4) @(negedge clk);
        check(done && fail == ef && pass == !ef, "R9 result held", int'(fail), int'(ef));
    endtask

    initial begin
        void'($urandom(32'h5ca1ab1e));
        repeat (3) @(negedge clk);
        check(!done && !pass && !fail, "R1 reset status", int'({done, pass, fail}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!{scan_gen_step, shift_clk, pi_gen_step, func_clk, po_comp_step,
                serial_comp_step, cmp_req, done}, "R1 idle strobes", 0, 0);
        run(1'b0, NW, 1'b0);
        run(1'b0, NW - 1, 1'b0);
        run(1'b0, 0, 1'b0);
        run(1'b1, NW, 1'b1);
        run(1'b1, 0, 1'b0);
        run(1'b1, NW - 1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            run(1'($urandom_range(0, 1)), int'($urandom_range(0, NW)), 1'($urandom_range(0, 1)));
        end
        finish_run();
    end
endmodule